// File: doc/BRIEF.md
# Composite-Field Byte Substitution Unit

This block computes an 8-bit substitution without storing any table. Each incoming byte is moved by a linear map into a tower representation: GF(2^8) built as a quadratic extension of GF(2^4), which is a quadratic extension of GF(2^2). The byte is inverted there using only subfield gate networks and mapped back. An optional affine step then turns the field inverse into the standard AES substitution value. The input-side and output-side 8x8 bit matrices are derived while the design elaborates, from the tower's defining constants, and are applied as XOR trees.

At each level an element is a pair (X0, X1) over the basis (1, a), where a^2 = a + N and N is chosen so that the extension polynomial is irreducible. A product takes three subfield multiplications plus one multiplication by N. An inverse takes one subfield inversion, one squaring, one multiplication by N and three multiplications. At the bottom level, GF(2^2) arithmetic is a handful of AND and XOR gates.

The result is registered, so a new byte can be accepted on every clock. A parameter chooses between the AES substitution (`AFFINE_EN = 1`) and the raw field inverse (`AFFINE_EN = 0`).

Top module: `tower_sbox`

## Requirements
- R1: With AFFINE_EN = 0, out_byte is the multiplicative inverse of the input in GF(2^8) modulo x^8+x^4+x^3+x+1, where bit k of a byte is the coefficient of x^k; input 0x00 gives 0x00 (for example 0x01 gives 0x01 and 0x53 gives 0xCA).
- R2: With AFFINE_EN = 1, out_byte is b XOR (b rotl 1) XOR (b rotl 2) XOR (b rotl 3) XOR (b rotl 4) XOR 0x63, where b is the R1 inverse; so 0x00 gives 0x63, 0x01 gives 0x7C and 0x53 gives 0xED.
- R3: out_valid is high in the cycle after a rising edge of clk at which in_valid was high, and low after an edge at which in_valid was low. out_byte then carries the result for the in_byte sampled at that edge.
- R4: A new byte can be presented on every cycle; back-to-back inputs produce back-to-back results in the same order.
- R5: After an edge at which in_valid is low, out_byte keeps its previous value.
- R6: While rst_n is low (asynchronous, active low), out_valid and out_byte are 0.
- R7: Over all 256 inputs, the outputs in either mode are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_byte holds a byte to substitute |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | out_byte holds a new result |
| out_byte | output | 8 | Substituted byte (or raw inverse) |

## Verification
Every result is due exactly one clock after the edge that samples its input. out_valid and out_byte both change at that edge. The driver changes inputs only on falling edges and pushes the expected pair (AES value and raw inverse) into a queue. The monitor wakes 2 ns after each rising edge, requires out_valid to equal the in_valid that was just sampled, and pops one expected item for each valid result. When no result is valid, the monitor instead requires out_byte to be unchanged. The expected values come from a brute-force polynomial-basis inverse and a rotation-form affine step in the bench. Nothing is copied from the tower arithmetic.

// File: rtl/tower_sbox.sv
module tower_sbox #(
  parameter bit AFFINE_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);

  // GF(2^2): basis (1,w), w^2 = w + 1; bit1 is the w coefficient
  function automatic logic [1:0] g4_mul(input logic [1:0] a, input logic [1:0] b);
    logic ll, hh, mm;
    ll = a[0] & b[0];
    hh = a[1] & b[1];
    mm = (a[0] ^ a[1]) & (b[0] ^ b[1]);
    return {mm ^ ll, ll ^ hh};
  endfunction

  function automatic logic [1:0] g4_sq(input logic [1:0] a);
    return {a[1], a[0] ^ a[1]};
  endfunction

  function automatic logic [1:0] g4_mulw(input logic [1:0] a);
    return {a[0] ^ a[1], a[1]};
  endfunction

  function automatic logic [1:0] g4_inv(input logic [1:0] a);
    logic d;
    d = (a[0] & (a[0] ^ a[1])) ^ a[1];
    return {a[1] & d, (a[0] ^ a[1]) & d};
  endfunction

  // GF(2^4): basis (1,z), z^2 = z + w
  function automatic logic [3:0] g16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] ll, hh, mm;
    ll = g4_mul(a[1:0], b[1:0]);
    hh = g4_mul(a[3:2], b[3:2]);
    mm = g4_mul(a[1:0] ^ a[3:2], b[1:0] ^ b[3:2]);
    return {mm ^ ll, ll ^ g4_mulw(hh)};
  endfunction

  function automatic logic [3:0] g16_sq(input logic [3:0] a);
    logic [1:0] s1;
    s1 = g4_sq(a[3:2]);
    return {s1, g4_sq(a[1:0]) ^ g4_mulw(s1)};
  endfunction

  function automatic logic [3:0] g16_inv(input logic [3:0] a);
    logic [1:0] d, di;
    d  = g4_mul(a[1:0], a[1:0] ^ a[3:2]) ^ g4_mulw(g4_sq(a[3:2]));
    di = g4_inv(d);
    return {g4_mul(a[3:2], di), g4_mul(a[1:0] ^ a[3:2], di)};
  endfunction

  // norm constant of the top extension: first c with x^2+x+c irreducible over GF(2^4)
  function automatic logic [3:0] pick_norm();
    logic [3:0] res;
    logic       found, has_root;
    res = 4'h0;
    found = 1'b0;
    for (int c = 1; c < 16; c++) begin
      has_root = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((g16_sq(4'(t)) ^ 4'(t) ^ 4'(c)) == 4'h0) has_root = 1'b1;
      if (!has_root && !found) begin
        res = 4'(c);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  localparam logic [3:0] NORM8 = pick_norm();

  function automatic logic [3:0] g16_muln(input logic [3:0] a);
    return g16_mul(a, NORM8);
  endfunction

  // GF(2^8): basis (1,y), y^2 = y + NORM8
  function automatic logic [7:0] g256_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] ll, hh, mm;
    ll = g16_mul(a[3:0], b[3:0]);
    hh = g16_mul(a[7:4], b[7:4]);
    mm = g16_mul(a[3:0] ^ a[7:4], b[3:0] ^ b[7:4]);
    return {mm ^ ll, ll ^ g16_muln(hh)};
  endfunction

  function automatic logic [7:0] g256_inv(input logic [7:0] a);
    logic [3:0] d, di;
    d  = g16_mul(a[3:0], a[3:0] ^ a[7:4]) ^ g16_muln(g16_sq(a[7:4]));
    di = g16_inv(d);
    return {g16_mul(a[7:4], di), g16_mul(a[3:0] ^ a[7:4], di)};
  endfunction

  // 8x8 bit matrix, column j at bits [8j +: 8]
  function automatic logic [7:0] mat_apply(input logic [63:0] m, input logic [7:0] v);
    logic [7:0] r;
    r = 8'h00;
    for (int j = 0; j < 8; j++)
      if (v[j]) r ^= m[8*j +: 8];
    return r;
  endfunction

  // poly -> tower: x^k maps to g^k, g a tower root of x^8+x^4+x^3+x+1
  function automatic logic [63:0] build_map_in();
    logic [7:0]  g, g2, g3, g4, g8, p, pw;
    logic [63:0] m;
    logic        found;
    g = 8'h00;
    found = 1'b0;
    for (int t = 2; t < 256; t++) begin
      g2 = g256_mul(8'(t), 8'(t));
      g3 = g256_mul(g2, 8'(t));
      g4 = g256_mul(g2, g2);
      g8 = g256_mul(g4, g4);
      p  = g8 ^ g4 ^ g3 ^ 8'(t) ^ 8'h01;
      if (p == 8'h00 && !found) begin
        g = 8'(t);
        found = 1'b1;
      end
    end
    m  = 64'h0;
    pw = 8'h01;
    for (int k = 0; k < 8; k++) begin
      m[8*k +: 8] = pw;
      pw = g256_mul(pw, g);
    end
    return m;
  endfunction

  function automatic logic [63:0] build_map_out(input logic [63:0] fwd);
    logic [63:0] m;
    m = 64'h0;
    for (int j = 0; j < 8; j++)
      for (int b = 0; b < 256; b++)
        if (mat_apply(fwd, 8'(b)) == (8'h01 << j)) m[8*j +: 8] = 8'(b);
    return m;
  endfunction

  function automatic logic [7:0] affine_lin(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return r;
  endfunction

  function automatic logic [63:0] build_out_mat(input logic [63:0] back);
    logic [63:0] m;
    for (int j = 0; j < 8; j++)
      m[8*j +: 8] = AFFINE_EN ? affine_lin(back[8*j +: 8]) : back[8*j +: 8];
    return m;
  endfunction

  localparam logic [63:0] MAP_IN    = build_map_in();
  localparam logic [63:0] MAP_OUT   = build_map_out(MAP_IN);
  localparam logic [63:0] OUT_MAT   = build_out_mat(MAP_OUT);
  localparam logic [7:0]  OUT_CONST = AFFINE_EN ? 8'h63 : 8'h00;

  logic [7:0] tw_in, tw_inv, sub_byte;

  assign tw_in    = mat_apply(MAP_IN, in_byte);
  assign tw_inv   = g256_inv(tw_in);
  assign sub_byte = mat_apply(OUT_MAT, tw_inv) ^ OUT_CONST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_byte <= sub_byte;
    end
  end

  a_r1_inverse_product: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tw_in != 8'h00) |-> (g256_mul(tw_in, tw_inv) == 8'h01));

  a_r2_zero_maps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte == 8'h00) |=> (out_byte == OUT_CONST));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_byte));

endmodule

// File: tb/tower_sbox_bench.sv
`timescale 1ns/1ps
module tower_sbox_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, raw_valid;
  logic [7:0] out_byte, raw_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;
  logic [7:0]  inv_ref [256];
  logic [15:0] exp_q [$];
  logic [255:0] seen_aes = '0, seen_raw = '0;
  logic [7:0] last_aes = 8'h00, last_raw = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  tower_sbox #(.AFFINE_EN(1'b1)) u_tower_sbox (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte));

  tower_sbox #(.AFFINE_EN(1'b0)) u_tower_sbox_raw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(raw_valid), .out_byte(raw_byte));

  function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] aes_of(input logic [7:0] b);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    exp_q.push_back({aes_of(inv_ref[b]), inv_ref[b]});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic spot(input logic [7:0] b, input logic [7:0] aes, input logic [7:0] raw);
    drive(b);
    @(posedge clk);
    #3;
    check(out_byte == aes, "R2", $sformatf("aes spot in=%02h", b), out_byte, aes);
    check(raw_byte == raw, "R1", $sformatf("raw spot in=%02h", b), raw_byte, raw);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      last_aes = 8'h00;
      last_raw = 8'h00;
    end else if (!done) begin
      check(out_valid == in_valid, "R3", "aes out_valid", 8'(out_valid), 8'(in_valid));
      check(raw_valid == in_valid, "R3", "raw out_valid", 8'(raw_valid), 8'(in_valid));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "result with empty queue", out_byte, 8'h00);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(out_byte == e[15:8], "R2", "aes value", out_byte, e[15:8]);
          check(raw_byte == e[7:0],  "R1", "raw inverse", raw_byte, e[7:0]);
          seen_aes[out_byte] = 1'b1;
          seen_raw[raw_byte] = 1'b1;
        end
        last_aes = out_byte;
        last_raw = raw_byte;
      end else begin
        check(out_byte == last_aes, "R5", "aes hold", out_byte, last_aes);
        check(raw_byte == last_raw, "R5", "raw hold", raw_byte, last_raw);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    inv_ref[0] = 8'h00;
    for (int a = 1; a < 256; a++)
      for (int b = 1; b < 256; b++)
        if (pmul(8'(a), 8'(b)) == 8'h01) inv_ref[a] = 8'(b);

    // R6: reset state
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && raw_valid == 1'b0, "R6", "valid in reset", 8'(out_valid), 8'h00);
    check(out_byte == 8'h00 && raw_byte == 8'h00, "R6", "byte in reset", out_byte, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: back-to-back sweep of all 256 inputs
    for (int i = 0; i < 256; i++) drive(8'(i));
    idle(3);
    check(exp_q.size() == 0, "R4", "queue drained", 8'(exp_q.size()), 8'h00);
    check(&seen_aes, "R7", "aes outputs distinct", 8'($countones(seen_aes) - 1), 8'hFF);
    check(&seen_raw, "R7", "raw outputs distinct", 8'($countones(seen_raw) - 1), 8'hFF);

    // R1/R2: fixed values
    spot(8'h00, 8'h63, 8'h00);
    spot(8'h01, 8'h7C, 8'h01);
    spot(8'h53, 8'hED, 8'hCA);
    idle(2);

    // R5/R3: inputs separated by idle gaps
    drive(8'hA5); idle(3);
    drive(8'h3C); idle(1);
    drive(8'hFF); drive(8'h80); idle(4);
    drive(8'h10); idle(2);
    check(exp_q.size() == 0, "R3", "gap queue drained", 8'(exp_q.size()), 8'h00);

    // R6: asynchronous reset mid-run
    drive(8'h77);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0 && raw_valid == 1'b0, "R6", "valid after async reset", 8'(out_valid), 8'h00);
    check(out_byte == 8'h00 && raw_byte == 8'h00, "R6", "byte after async reset", out_byte, 8'h00);
    done = 1'b1;
    exp_q.delete();
    @(posedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule